// File: doc/BRIEF.md
# Register-driven I2C master transmitter

This block is the transmit half of an I2C master, run entirely through a small register file. Software first loads a clock setting, enables the interface and places the destination address byte in the data register. It then writes a fixed start command into the status register. The engine issues a START, shifts the address byte out most-significant bit first and clocks the acknowledge slot. Each later write to the data register, made while the bus is held between bytes, sends one more byte and its acknowledge clock. A stop command written to the status register ends the transfer with a STOP. A missing acknowledge ends it with a STOP with no command needed.

The bus pins are open-drain. An output enable of 1 pulls the line low, and 0 releases it. SDA is read back on `sda_in`. The register write port is a valid/ready stream. A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. While a START, a byte or a STOP is being clocked, `wr_ready` stays low, and the writer must hold `wr_valid`, `wr_addr` and `wr_data` steady until the write is taken. The read port is plain and combinational. `irq` is a one-cycle pulse at the end of each byte and its acknowledge slot.

Register indices on `wr_addr`/`rd_addr`:
- 0 is the own address.
- 1 is clock control.
- 2 is status and command.
- 3 is control.
- 4 is the data register.

Top module: `i2ct_master_tx`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe` and `irq` are 0, `wr_ready` is 1, and the status register (index 2) reads 0x00.
- R2: A status write whose upper nibble is 0xF, made while control bit 3 is 1 and the bus is idle, pulls SDA low while SCL stays released. SCL is first pulled low exactly two quarter periods later.
- R3: Each byte is sent MSB first. SDA changes only while SCL is low. There are 8 SCL pulses, plus a ninth acknowledge pulse when clock-control bit 7 is 1.
- R4: The SCL period is 4 × (clock-control bits 4..0 + 1) × P system clocks. P is `PRE_STD` when clock-control bit 5 is 0 and `PRE_FAST` when it is 1.
- R5: At the end of every byte's last SCL pulse, `irq` pulses for one cycle and status bit 4 (pending) reads 0. Pending reads 1 from the start command or from a data write that launches a byte. A data write (index 4) while the bus is held sends the written byte.
- R6: Status bit 0 holds the SDA level sampled in the acknowledge slot (1 = no acknowledge). It reads 0 when no acknowledge clock is generated. A missing acknowledge is followed by a STOP with no command.
- R7: A status write whose upper nibble is 0xD, made while the bus is held, produces a STOP: SDA rises while SCL is high, then both lines are released. Status bit 5 (bus busy) reads 1 from the start command until the STOP completes.
- R8: With control bit 3 at 0, a start command leaves both lines released and bus busy at 0.
- R9: `wr_ready` is 0 while a START, a byte or a STOP is being clocked. A write presented then is held off and is taken once the bus is held or idle.
- R10: The own-address, clock-control, control and data registers read back the last value written. Status bits 7 and 6 read back the last values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write offered |
| wr_ready | output | 1 | Register write can be taken this cycle |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register index for the read |
| rd_data | output | 8 | Read data, combinational |
| irq | output | 1 | One-cycle pulse at the end of each byte |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
The bench targets four cases:
- A slave that withholds the acknowledge, where a design that ignored the sampled level would keep the bus held and wait forever for a stop command.
- The smallest divider in fast mode, where the quarter period is one clock and an off-by-one tick counter would stretch every SCL phase.
- A write presented in mid-byte, which a design without back-pressure would apply while bits are still shifting.
- The acknowledge clock turned off, where a design that still clocked it would emit nine pulses and could report a false missing acknowledge.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int DIVW = 5;

  localparam logic [AW-1:0] RA_OWN  = 3'd0;
  localparam logic [AW-1:0] RA_CLK  = 3'd1;
  localparam logic [AW-1:0] RA_STAT = 3'd2;
  localparam logic [AW-1:0] RA_CTRL = 3'd3;
  localparam logic [AW-1:0] RA_DATA = 3'd4;

  localparam int CTL_EN_BIT  = 3;
  localparam int CK_ACK_BIT  = 7;
  localparam int CK_FAST_BIT = 5;

  localparam logic [3:0] CMD_START = 4'hF;
  localparam logic [3:0] CMD_STOP  = 4'hD;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_START,
    EN_BIT,
    EN_HOLD,
    EN_STOP
  } eng_state_t;
endpackage

// File: rtl/i2ct_qtick.sv
module i2ct_qtick #(
  parameter int PRE_STD  = 4,
  parameter int PRE_FAST = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic [i2ct_pkg::DIVW-1:0] div,
  input  logic                     fast,
  output logic                     tick
);
  localparam int PRE_MAX = (PRE_STD > PRE_FAST) ? PRE_STD : PRE_FAST;
  localparam int QW = $clog2((1 << i2ct_pkg::DIVW) * PRE_MAX + 1);

  logic [QW-1:0] qlen;
  logic [QW-1:0] cnt_q;

  // quarter SCL period in system clocks
  always_comb qlen = QW'((int'(div) + 1) * (fast ? PRE_FAST : PRE_STD));

  assign tick = run && (cnt_q == qlen - QW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + QW'(1);
  end

  // R4: the quarter counter never passes its limit while running
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < qlen));
endmodule

// File: rtl/i2ct_txeng.sv
module i2ct_txeng (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   go_start,
  input  logic                   go_byte,
  input  logic                   stop_arm,
  input  logic                   ack_en,
  input  logic [i2ct_pkg::DW-1:0] tx_byte,
  input  logic                   sda_in,
  output logic                   scl_oe,
  output logic                   sda_oe,
  output logic                   run,
  output logic                   busy,
  output logic                   hold,
  output logic                   byte_done,
  output logic                   lrb
);
  import i2ct_pkg::*;

  eng_state_t     st_q;
  logic [1:0]     ph_q;
  logic [3:0]     bitn_q;
  logic [DW-1:0]  sh_q;
  logic           scl_oe_q, sda_oe_q, lrb_q, done_q;
  logic           ack_slot, last;

  assign ack_slot = (bitn_q == 4'd8);
  assign last     = ack_en ? (bitn_q == 4'd8) : (bitn_q == 4'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= EN_IDLE;
      ph_q     <= '0;
      bitn_q   <= '0;
      sh_q     <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      lrb_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        EN_IDLE: begin
          if (go_start) begin
            st_q     <= EN_START;
            ph_q     <= '0;
            sda_oe_q <= 1'b1;
            sh_q     <= tx_byte;
            bitn_q   <= '0;
            lrb_q    <= 1'b0;
          end
        end
        EN_START: begin
          if (tick) begin
            if (ph_q == 2'd1) begin
              scl_oe_q <= 1'b1;
              st_q     <= EN_BIT;
              ph_q     <= '0;
            end else begin
              ph_q <= ph_q + 2'd1;
            end
          end
        end
        EN_BIT: begin
          if (tick) begin
            ph_q <= ph_q + 2'd1;
            case (ph_q)
              2'd0: sda_oe_q <= ack_slot ? 1'b0 : ~sh_q[DW-1];
              2'd1: scl_oe_q <= 1'b0;
              2'd2: if (ack_slot) lrb_q <= sda_in;
              default: begin
                scl_oe_q <= 1'b1;
                if (last) begin
                  done_q <= 1'b1;
                  if ((ack_en && lrb_q) || stop_arm) begin
                    st_q     <= EN_STOP;
                    sda_oe_q <= 1'b1;
                  end else begin
                    st_q <= EN_HOLD;
                  end
                end else begin
                  bitn_q <= bitn_q + 4'd1;
                  sh_q   <= {sh_q[DW-2:0], 1'b0};
                end
              end
            endcase
          end
        end
        EN_HOLD: begin
          if (stop_arm) begin
            st_q     <= EN_STOP;
            ph_q     <= '0;
            sda_oe_q <= 1'b1;
          end else if (go_byte) begin
            st_q   <= EN_BIT;
            ph_q   <= '0;
            sh_q   <= tx_byte;
            bitn_q <= '0;
            lrb_q  <= 1'b0;
          end
        end
        EN_STOP: begin
          if (tick) begin
            ph_q <= ph_q + 2'd1;
            case (ph_q)
              2'd0: scl_oe_q <= 1'b0;
              2'd1: sda_oe_q <= 1'b0;
              2'd3: st_q <= EN_IDLE;
              default: ;
            endcase
          end
        end
        default: st_q <= EN_IDLE;
      endcase
    end
  end

  assign scl_oe    = scl_oe_q;
  assign sda_oe    = sda_oe_q;
  assign run       = (st_q == EN_START) || (st_q == EN_BIT) || (st_q == EN_STOP);
  assign busy      = (st_q != EN_IDLE);
  assign hold      = (st_q == EN_HOLD);
  assign byte_done = done_q;
  assign lrb       = lrb_q;

  // R2: while the START is shaped, SDA is pulled and SCL is released
  p_start_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == EN_START) |-> (sda_oe_q && !scl_oe_q));

  // R3: SDA holds still while SCL is high inside a byte
  p_sda_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == EN_BIT && $past(st_q) == EN_BIT && !scl_oe_q) |-> $stable(sda_oe_q));

  // R5: the end-of-byte strobe lasts one cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: a missing acknowledge leads straight into STOP
  p_nack_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ack_en && lrb_q) |-> (st_q == EN_STOP));
endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [i2ct_pkg::AW-1:0]   wr_addr,
  input  logic [i2ct_pkg::DW-1:0]   wr_data,
  input  logic [i2ct_pkg::AW-1:0]   rd_addr,
  output logic [i2ct_pkg::DW-1:0]   rd_data,
  input  logic                      run,
  input  logic                      busy,
  input  logic                      hold,
  input  logic                      byte_done,
  input  logic                      lrb,
  output logic                      go_start,
  output logic                      go_byte,
  output logic                      stop_arm,
  output logic [i2ct_pkg::DW-1:0]   tx_byte,
  output logic [i2ct_pkg::DIVW-1:0] div,
  output logic                      fast,
  output logic                      ack_en
);
  import i2ct_pkg::*;

  logic [DW-1:0] own_q, clk_q, ctrl_q, data_q;
  logic          mst_q, trx_q, pend_q, arm_q;
  logic          wr_fire, stop_cmd;

  assign wr_ready = !run;
  assign wr_fire  = wr_valid && wr_ready;
  assign go_start = wr_fire && (wr_addr == RA_STAT) && (wr_data[7:4] == CMD_START)
                    && ctrl_q[CTL_EN_BIT] && !busy;
  assign go_byte  = wr_fire && (wr_addr == RA_DATA) && hold;
  assign stop_cmd = wr_fire && (wr_addr == RA_STAT) && (wr_data[7:4] == CMD_STOP) && busy;
  assign tx_byte  = go_byte ? wr_data : data_q;
  assign stop_arm = arm_q;
  assign div      = clk_q[DIVW-1:0];
  assign fast     = clk_q[CK_FAST_BIT];
  assign ack_en   = clk_q[CK_ACK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '0;
      clk_q  <= '0;
      ctrl_q <= '0;
      data_q <= '0;
      mst_q  <= 1'b0;
      trx_q  <= 1'b0;
    end else if (wr_fire) begin
      case (wr_addr)
        RA_OWN:  own_q  <= wr_data;
        RA_CLK:  clk_q  <= wr_data;
        RA_CTRL: ctrl_q <= wr_data;
        RA_DATA: data_q <= wr_data;
        RA_STAT: begin
          mst_q <= wr_data[7];
          trx_q <= wr_data[6];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pend_q <= 1'b0;
    else if (go_start || go_byte)  pend_q <= 1'b1;
    else if (byte_done)            pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        arm_q <= 1'b0;
    else if (stop_cmd) arm_q <= 1'b1;
    else if (!busy)    arm_q <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      RA_OWN:  rd_data = own_q;
      RA_CLK:  rd_data = clk_q;
      RA_STAT: rd_data = {mst_q, trx_q, busy, pend_q, 3'b000, lrb};
      RA_CTRL: rd_data = ctrl_q;
      RA_DATA: rd_data = data_q;
      default: rd_data = '0;
    endcase
  end

  // R5: the end of a byte clears pending unless a new byte is launched
  p_pend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !go_byte) |=> !pend_q);

  // R8: the bus only becomes busy while the interface is enabled
  p_start_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ctrl_q[CTL_EN_BIT]);

  // R7: an armed stop moves the engine out of the held state
  p_stop_leaves_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && hold) |=> !hold);
endmodule

// File: rtl/i2ct_master_tx.sv
module i2ct_master_tx #(
  parameter int PRE_STD  = 4,
  parameter int PRE_FAST = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  import i2ct_pkg::*;

  logic            tick, run, busy, hold, byte_done, lrb;
  logic            go_start, go_byte, stop_arm, fast, ack_en;
  logic [DW-1:0]   tx_byte;
  logic [DIVW-1:0] div;

  i2ct_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .run      (run),
    .busy     (busy),
    .hold     (hold),
    .byte_done(byte_done),
    .lrb      (lrb),
    .go_start (go_start),
    .go_byte  (go_byte),
    .stop_arm (stop_arm),
    .tx_byte  (tx_byte),
    .div      (div),
    .fast     (fast),
    .ack_en   (ack_en)
  );

  i2ct_qtick #(.PRE_STD(PRE_STD), .PRE_FAST(PRE_FAST)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .div  (div),
    .fast (fast),
    .tick (tick)
  );

  i2ct_txeng u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .go_start (go_start),
    .go_byte  (go_byte),
    .stop_arm (stop_arm),
    .ack_en   (ack_en),
    .tx_byte  (tx_byte),
    .sda_in   (sda_in),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .run      (run),
    .busy     (busy),
    .hold     (hold),
    .byte_done(byte_done),
    .lrb      (lrb)
  );

  assign irq = byte_done;
endmodule

// File: tb/i2ct_master_tx_test.sv
module i2ct_master_tx_test;
  localparam int PS = 4;
  localparam int PF = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] rd_addr = 3'd2;
  logic [7:0] rd_data;
  logic       irq, scl_oe, sda_oe, sda_in;
  logic       slv_pull = 1'b0;

  assign sda_in = ~(sda_oe | slv_pull);

  i2ct_master_tx #(.PRE_STD(PS), .PRE_FAST(PF)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  always #2 clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  // bus monitor and slave model state
  int       cyc = 0, irq_cnt = 0, start_cnt = 0, stop_cnt = 0;
  int       bitc = 0, rif = 0, r1 = 0, per = 0, start_cyc = 0, start_gap = 0;
  bit       gap_pend = 0, prev_scl = 1, prev_sda = 1, ack_en_tb = 0;
  logic [7:0] sh = 8'd0;
  logic [7:0] got [0:63];
  int       pulses [0:63];
  int       got_n = 0;
  bit       plan_ack [0:63];
  logic [7:0] plan_byte [0:7];

  always @(negedge clk) begin
    bit scl_now, sda_now;
    cyc++;
    scl_now = ~scl_oe;
    sda_now = sda_in;
    if (irq) irq_cnt++;
    if (prev_scl && scl_now && prev_sda && !sda_now) begin
      start_cnt++; bitc = 0; rif = 0; start_cyc = cyc; gap_pend = 1;
    end else if (prev_scl && scl_now && !prev_sda && sda_now) begin
      stop_cnt++; bitc = 0; rif = 0;
    end
    if (!prev_scl && scl_now) begin
      bitc++; rif++;
      if (bitc <= 8) sh = {sh[6:0], sda_now};
      if (bitc == 1) r1 = cyc;
      if (bitc == 2) per = cyc - r1;
      if (bitc == 8 && got_n < 64) begin got[got_n] = sh; got_n++; end
    end
    if (prev_scl && !scl_now) begin
      if (gap_pend) begin start_gap = cyc - start_cyc; gap_pend = 0; end
      if (bitc == 8 && got_n > 0) begin
        if (ack_en_tb) slv_pull = plan_ack[got_n-1];
        else begin pulses[got_n-1] = rif; bitc = 0; rif = 0; end
      end else if (bitc == 9 && got_n > 0) begin
        slv_pull = 1'b0; pulses[got_n-1] = rif; bitc = 0; rif = 0;
      end
    end
    prev_scl = scl_now;
    prev_sda = sda_now;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input logic [7:0] ck);
    return 4 * (int'(ck[4:0]) + 1) * (ck[5] ? PF : PS);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d, output int stall);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; stall = 0;
    while (!wr_ready) begin @(negedge clk); stall++; end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic wait_irq(input int target);
    int t = 0;
    while (irq_cnt < target && t < 30000) begin @(negedge clk); t++; end
    chk("R5 irq arrival", irq_cnt >= target, 1);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int t = 0;
    rd(3'd2, s);
    while (s[5] && t < 30000) begin rd(3'd2, s); t++; end
    chk("R7 bus busy clears", int'(s[5]), 0);
  endtask

  task automatic run_xfer(input logic [7:0] ck, input int nb);
    int base, s0, p0, i0, sent, st;
    bit nack;
    logic [7:0] s;
    ack_en_tb = ck[7];
    base = got_n; s0 = start_cnt; p0 = stop_cnt; i0 = irq_cnt; sent = 0; nack = 0;
    wr(3'd1, ck, st);
    wr(3'd4, plan_byte[0], st);
    wr(3'd2, 8'hF0, st);
    chk("R9 ready low during byte", int'(wr_ready), 0);
    rd(3'd2, s);
    chk("R7 busy after start", int'(s[5]), 1);
    chk("R5 pending after start", int'(s[4]), 1);
    for (int i = 0; i < nb; i++) begin
      wait_irq(i0 + i + 1);
      rd(3'd2, s);
      chk("R5 pending cleared", int'(s[4]), 0);
      chk("R6 ack level bit", int'(s[0]), int'(ck[7] && !plan_ack[base+i]));
      sent++;
      if (ck[7] && !plan_ack[base+i]) begin nack = 1; break; end
      if (i < nb - 1) wr(3'd4, plan_byte[i+1], st);
    end
    if (!nack) wr(3'd2, 8'hD0, st);
    wait_idle();
    chk("R2 one start", start_cnt, s0 + 1);
    chk("R7 one stop", stop_cnt, p0 + 1);
    chk("R2 start hold", start_gap, exp_period(ck) / 2);
    chk("R4 scl period", per, exp_period(ck));
    chk("R3 byte count", got_n, base + sent);
    chk("R5 irq count", irq_cnt, i0 + sent);
    for (int k = 0; k < sent; k++) begin
      chk("R3 byte value", int'(got[base+k]), int'(plan_byte[k]));
      chk("R3 pulses", pulses[base+k], ck[7] ? 9 : 8);
    end
    chk("R7 lines released", int'(scl_oe | sda_oe), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int st;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 wr_ready", int'(wr_ready), 1);
    rd(3'd2, v); chk("R1 status", int'(v), 0);

    // R10 readback
    wr(3'd0, 8'h5A, st); wr(3'd1, 8'h85, st); wr(3'd3, 8'h00, st);
    wr(3'd4, 8'hC3, st); wr(3'd2, 8'hC0, st);
    rd(3'd0, v); chk("R10 own", int'(v), 8'h5A);
    rd(3'd1, v); chk("R10 clock", int'(v), 8'h85);
    rd(3'd3, v); chk("R10 control", int'(v), 8'h00);
    rd(3'd4, v); chk("R10 data", int'(v), 8'hC3);
    rd(3'd2, v); chk("R10 status", int'(v), 8'hC0);

    // R8 start ignored while disabled
    wr(3'd2, 8'h10, st);
    wr(3'd2, 8'hF0, st);
    repeat (200) @(negedge clk);
    chk("R8 scl released", int'(scl_oe), 0);
    chk("R8 sda released", int'(sda_oe), 0);
    chk("R8 no start", start_cnt, 0);
    rd(3'd2, v); chk("R8 not busy", int'(v[5]), 0);

    wr(3'd3, 8'h08, st);

    // directed: three bytes, all acknowledged, standard mode
    plan_byte[0] = 8'hA4; plan_byte[1] = 8'h3C; plan_byte[2] = 8'hFF;
    for (int k = 0; k < 3; k++) plan_ack[got_n+k] = 1;
    run_xfer(8'h85, 3);

    // directed: address not acknowledged -> automatic stop (R6)
    plan_byte[0] = 8'h90; plan_byte[1] = 8'h11;
    plan_ack[got_n] = 0; plan_ack[got_n+1] = 1;
    run_xfer(8'h83, 2);

    // directed: no acknowledge clock, fast mode
    plan_byte[0] = 8'h6E; plan_byte[1] = 8'h01;
    plan_ack[got_n] = 0; plan_ack[got_n+1] = 0;
    run_xfer(8'h25, 2);

    // directed: fastest divider, one-clock quarter
    plan_byte[0] = 8'h81; plan_ack[got_n] = 1;
    run_xfer(8'hA0, 1);

    // R9: a write in mid-byte is held until the byte finishes
    begin
      int i0;
      ack_en_tb = 1;
      plan_ack[got_n] = 1;
      wr(3'd1, 8'h82, st);
      wr(3'd4, 8'h5E, st);
      i0 = irq_cnt;
      wr(3'd2, 8'hF0, st);
      wr(3'd0, 8'h11, st);
      chk("R9 stalled", int'(st > 0), 1);
      chk("R9 taken after byte", irq_cnt, i0 + 1);
      rd(3'd0, v); chk("R9 held write landed", int'(v), 8'h11);
      wr(3'd2, 8'hD0, st);
      wait_idle();
      chk("R9 byte intact", int'(got[got_n-1]), 8'h5E);
    end

    // constrained random transfers
    for (int t = 0; t < 8; t++) begin
      logic [7:0] ck;
      int nb;
      ck = {($urandom % 4) != 0, 1'b0, 1'($urandom % 2), 5'($urandom % 8)};
      nb = 1 + ($urandom % 3);
      for (int k = 0; k < nb; k++) begin
        plan_byte[k] = 8'($urandom);
        plan_ack[got_n+k] = ($urandom % 5) != 0;
      end
      run_xfer(ck, nb);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule